// File: doc/BRIEF.md
# Mapped Page Replay Scanner

The scanner walks an address-translation window one page at a time and reports every page that carries a usable mapping. A newly attached observer, such as a device-side translation cache, can use this stream to rebuild its own copy of the mappings without reading the whole table itself.

A scan begins with a one-cycle `start` pulse. The window is described by a page shift and an entry count, and its size is the count shifted left by the shift. The scanner asks the translation unit about each page address in turn over a request/acknowledge port. For every answer whose permission is not no-access, it presents an event on a valid/ready stream. A skip input makes the scanner finish at once without scanning. `done` marks the end of every scan, including a skipped scan and a scan of an empty window.

The address counter stops safely if the next page address would pass the top of the address space. This can happen when the window is larger than the space, or when a single page is at least as large as the space.

Top module: `pg_replay_scanner`

## Requirements
- R1: Successive lookup addresses within one scan differ by exactly the page size, 1 << `page_shift`, and the first lookup address is 0.
- R2: Lookups cover every page address from 0 up to but not including the window size, `entry_count << page_shift`. That size is clamped to 2^ADDR_W. An entry count of 0 produces no lookups.
- R3: Permission codes are 2'b00 no-access, 2'b01 read-only, 2'b10 write-only and 2'b11 read-write. An event is produced for every looked-up page whose code is not 2'b00, and for no other page.
- R4: The scan ends after the lookup at address A when A + page size would reach 2^ADDR_W. The address counter never wraps back to a low address.
- R5: When `skip` is high in the cycle `start` is sampled, no lookup and no event occur, and `done` is high in the very next cycle.
- R6: `done` is high for exactly one cycle per scan. It is high in the second cycle after the clock edge at which the last page is finished, meaning its lookup was answered with no-access or its event was accepted. For an empty window it is high one cycle after `start`. After reset, `busy`, `done`, `lk_req` and `ev_valid` are low.
- R7: `ev_valid` stays high with stable contents until `ev_ready` is high, and no lookup is requested while an event is pending.
- R8: A `start` pulse while `busy` is high is ignored. The current scan goes on unchanged and produces a single `done`.
- R9: Each event carries the page address that was looked up, together with the target address and permission code returned for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (sampled while idle) |
| skip | input | 1 | With start: finish without scanning |
| page_shift | input | SHIFT_W | Log2 of the page size |
| entry_count | input | COUNT_W | Number of entries in the window |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| lk_req | output | 1 | Lookup request, held until acknowledged |
| lk_addr | output | ADDR_W | Page address being looked up |
| lk_ack | input | 1 | Lookup answer valid |
| lk_perm | input | 2 | Permission code of the answer |
| lk_target | input | ADDR_W | Target address of the answer |
| ev_valid | output | 1 | Mapping event valid |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_addr | output | ADDR_W | Page address of the event |
| ev_target | output | ADDR_W | Target address of the event |
| ev_perm | output | 2 | Permission code of the event |

## Verification
Scans are run over several window shapes:
- Fine pages of size 1 show the step arithmetic at its smallest.
- Medium pages with a consumer that is always ready show the fastest event path.
- Pages with a throttled consumer separate event holding from lookup ordering.
- A window larger than the address space shows the wrap stop.
- A page larger than the whole space, an empty window and a skipped scan each show a different early finish.

The responder returns a mix of all four permission codes, so every scan shows that fault pages are dropped while the other three codes pass through. A start pulse arriving in the middle of a scan shows that an active scan cannot be restarted.

// File: rtl/pg_scan_pkg.sv
package pg_scan_pkg;
  typedef enum logic [2:0] {
    SC_IDLE    = 3'd0,
    SC_REQ     = 3'd1,
    SC_EMIT    = 3'd2,
    SC_ADVANCE = 3'd3,
    SC_DONE    = 3'd4
  } scan_state_t;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RD   = 2'b01;
  localparam logic [1:0] PERM_WR   = 2'b10;
  localparam logic [1:0] PERM_RW   = 2'b11;
endpackage

// File: rtl/pg_scan_addr_gen.sv
module pg_scan_addr_gen #(
  parameter int ADDR_W  = 12,
  parameter int SHIFT_W = 4,
  parameter int COUNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic [SHIFT_W-1:0] shift_in,
  input  logic [COUNT_W-1:0] count_in,
  output logic [ADDR_W-1:0]  addr,
  output logic [ADDR_W:0]    limit,
  output logic               in_empty,
  output logic               last,
  output logic               wrap
);
  localparam int WIDE_W = COUNT_W + (1 << SHIFT_W);
  localparam logic [WIDE_W-1:0] SPACE = WIDE_W'(1) << ADDR_W;

  function automatic logic [WIDE_W-1:0] window_of(input logic [COUNT_W-1:0] cnt,
                                                  input logic [SHIFT_W-1:0] sh);
    return WIDE_W'(cnt) << sh;
  endfunction

  function automatic logic [ADDR_W:0] clamp_to_space(input logic [WIDE_W-1:0] w);
    return (w > SPACE) ? SPACE[ADDR_W:0] : w[ADDR_W:0];
  endfunction

  logic [ADDR_W-1:0]  addr_q;
  logic [ADDR_W:0]    limit_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [WIDE_W-1:0]  step_w;
  logic [WIDE_W-1:0]  next_w;

  always_comb begin
    step_w = WIDE_W'(1) << shift_q;
    next_w = WIDE_W'(addr_q) + step_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      limit_q <= '0;
      shift_q <= '0;
    end else if (load) begin
      addr_q  <= '0;
      shift_q <= shift_in;
      limit_q <= clamp_to_space(window_of(count_in, shift_in));
    end else if (adv) begin
      addr_q <= next_w[ADDR_W-1:0];
    end
  end

  assign addr     = addr_q;
  assign limit    = limit_q;
  assign in_empty = (count_in == '0);
  assign last     = (next_w >= WIDE_W'(limit_q));
  assign wrap     = (next_w >= SPACE);

  // R1: every advance moves the counter upward, never back to a low address
  assert_addr_rises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (addr_q > $past(addr_q)));
  // R1: a fresh scan starts from page address zero
  assert_scan_from_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr_q == '0));
endmodule

// File: rtl/pg_scan_evt_buf.sv
module pg_scan_evt_buf #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] target_in,
  input  logic [1:0]        perm_in,
  input  logic              ready,
  output logic              valid,
  output logic              taken,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] target,
  output logic [1:0]        perm
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr    <= '0;
      target  <= '0;
      perm    <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      addr    <= addr_in;
      target  <= target_in;
      perm    <= perm_in;
    end else if (valid_q && ready) begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign taken = valid_q && ready;

  // R7: a stalled event keeps its contents
  assert_evt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(addr) && $stable(target) && $stable(perm)));
endmodule

// File: rtl/pg_scan_ctrl.sv
module pg_scan_ctrl
  import pg_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       skip,
  input  logic       in_empty,
  input  logic       lk_ack,
  input  logic [1:0] lk_perm,
  input  logic       taken,
  input  logic       last,
  input  logic       wrap,
  output logic       load,
  output logic       adv,
  output logic       lk_req,
  output logic       evt_load,
  output logic       busy,
  output logic       done
);
  scan_state_t st_q, st_d;
  logic        idle_start;

  assign idle_start = (st_q == SC_IDLE) && start;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    adv      = 1'b0;
    evt_load = 1'b0;
    unique case (st_q)
      SC_IDLE: if (start) begin
        load = 1'b1;
        st_d = (skip || in_empty) ? SC_DONE : SC_REQ;
      end
      SC_REQ: if (lk_ack) begin
        if (lk_perm != PERM_NONE) begin
          evt_load = 1'b1;
          st_d     = SC_EMIT;
        end else begin
          st_d = SC_ADVANCE;
        end
      end
      SC_EMIT: if (taken) st_d = SC_ADVANCE;
      SC_ADVANCE: begin
        if (last) begin
          st_d = SC_DONE;
        end else begin
          adv  = 1'b1;
          st_d = SC_REQ;
        end
      end
      SC_DONE: st_d = SC_IDLE;
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SC_IDLE;
    else        st_q <= st_d;
  end

  assign lk_req = (st_q == SC_REQ);
  assign busy   = (st_q != SC_IDLE);
  assign done   = (st_q == SC_DONE);

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: a skipped start finishes in the next cycle
  assert_skip_finishes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_start && skip) |=> (done && !lk_req));
  // R4: reaching the top of the space ends the scan
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SC_ADVANCE) && wrap) |=> done);
  // R8: start while busy does not restart the counter
  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !load);
endmodule

// File: rtl/pg_replay_scanner.sv
module pg_replay_scanner #(
  parameter int ADDR_W  = 12,
  parameter int SHIFT_W = 4,
  parameter int COUNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               skip,
  input  logic [SHIFT_W-1:0] page_shift,
  input  logic [COUNT_W-1:0] entry_count,
  output logic               busy,
  output logic               done,
  output logic               lk_req,
  output logic [ADDR_W-1:0]  lk_addr,
  input  logic               lk_ack,
  input  logic [1:0]         lk_perm,
  input  logic [ADDR_W-1:0]  lk_target,
  output logic               ev_valid,
  input  logic               ev_ready,
  output logic [ADDR_W-1:0]  ev_addr,
  output logic [ADDR_W-1:0]  ev_target,
  output logic [1:0]         ev_perm
);
  logic            load, adv, evt_load, taken;
  logic            in_empty, last, wrap;
  logic [ADDR_W:0] limit;

  pg_scan_addr_gen #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .COUNT_W(COUNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .shift_in(page_shift), .count_in(entry_count),
    .addr(lk_addr), .limit(limit), .in_empty(in_empty), .last(last), .wrap(wrap)
  );

  pg_scan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .skip(skip), .in_empty(in_empty),
    .lk_ack(lk_ack), .lk_perm(lk_perm), .taken(taken), .last(last), .wrap(wrap),
    .load(load), .adv(adv), .lk_req(lk_req), .evt_load(evt_load),
    .busy(busy), .done(done)
  );

  pg_scan_evt_buf #(.ADDR_W(ADDR_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .load(evt_load), .addr_in(lk_addr),
    .target_in(lk_target), .perm_in(lk_perm), .ready(ev_ready),
    .valid(ev_valid), .taken(taken), .addr(ev_addr), .target(ev_target), .perm(ev_perm)
  );

  // R2: every lookup stays inside the window
  assert_lookup_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> ({1'b0, lk_addr} < limit));
  // R3: no event ever carries the no-access code
  assert_evt_not_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_perm != 2'b00));
  // R7: no lookup while an event waits
  assert_no_lookup_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !lk_req);
endmodule

// File: tb/pg_replay_scanner_bench.sv
module pg_replay_scanner_bench;
  localparam int AW = 12;
  localparam int SPACE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, skip = 1'b0;
  logic [3:0]  page_shift = '0;
  logic [11:0] entry_count = '0;
  logic busy, done, lk_req, lk_ack = 1'b0, ev_valid, ev_ready = 1'b1;
  logic [AW-1:0] lk_addr, lk_target, ev_addr, ev_target;
  logic [1:0] lk_perm, ev_perm;

  int checks = 0, failures = 0;
  int cyc = 0, cur_shift = 0, stall = 0, rdy_cnt = 0;
  int n_lk = 0, n_ev = 0, n_done = 0, start_cyc = -1, last_proc = -1, done_cyc = -1;
  int lk_log [64];
  int ev_a_log [64];
  int ev_t_log [64];
  int ev_p_log [64];

  always #5 clk = ~clk;

  pg_replay_scanner u_pg_replay_scanner (
    .clk(clk), .rst_n(rst_n), .start(start), .skip(skip), .page_shift(page_shift),
    .entry_count(entry_count), .busy(busy), .done(done), .lk_req(lk_req),
    .lk_addr(lk_addr), .lk_ack(lk_ack), .lk_perm(lk_perm), .lk_target(lk_target),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
    .ev_target(ev_target), .ev_perm(ev_perm)
  );

  function automatic int perm_of(int a, int sh);
    return (((a >> sh) * 3) + 1) & 3;
  endfunction
  function automatic int target_of(int a);
    return (a ^ 12'h5A5) & (SPACE - 1);
  endfunction

  assign lk_perm   = 2'(perm_of(int'(lk_addr), cur_shift));
  assign lk_target = AW'(target_of(int'(lk_addr)));

  always @(posedge clk) begin
    lk_ack   <= lk_req && !lk_ack;
    rdy_cnt  <= (rdy_cnt + 1) % 3;
    ev_ready <= (stall != 0) ? (rdy_cnt == 2) : 1'b1;
    cyc      <= cyc + 1;
    if (start && !busy && rst_n) start_cyc = cyc;
    if (lk_req && lk_ack) begin
      if (n_lk < 64) lk_log[n_lk] = int'(lk_addr);
      n_lk++;
      if (lk_perm == 2'b00) last_proc = cyc;
    end
    if (ev_valid && ev_ready) begin
      if (n_ev < 64) begin
        ev_a_log[n_ev] = int'(ev_addr);
        ev_t_log[n_ev] = int'(ev_target);
        ev_p_log[n_ev] = int'(ev_perm);
      end
      n_ev++;
      last_proc = cyc;
    end
    if (done) begin
      n_done++;
      done_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input int sh, input int cnt, input bit sk);
    @(negedge clk);
    page_shift = 4'(sh); entry_count = 12'(cnt); skip = sk; start = 1'b1;
    @(negedge clk);
    start = 1'b0; skip = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (n_done == 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_logs(input int sh, input int st);
    @(negedge clk);
    cur_shift = sh; stall = st;
    n_lk = 0; n_ev = 0; n_done = 0; start_cyc = -1; last_proc = -1; done_cyc = -1;
  endtask

  // Compare one finished scan against a bench-side walk of the window.
  task automatic judge(input string req, input int sh, input int cnt, input bit sk);
    longint lim;
    longint a;
    int exp_lk = 0, exp_ev = 0;
    bit lk_ok = 1, ev_ok = 1;
    int exp_done;
    lim = longint'(cnt) << sh;
    if (lim > SPACE) lim = SPACE;
    if (sk) lim = 0;
    a = 0;
    while (a < lim) begin
      if (exp_lk >= n_lk || lk_log[exp_lk] != int'(a)) lk_ok = 0;
      exp_lk++;
      if (perm_of(int'(a), sh) != 0) begin
        if (exp_ev >= n_ev || ev_a_log[exp_ev] != int'(a) ||
            ev_t_log[exp_ev] != target_of(int'(a)) ||
            ev_p_log[exp_ev] != perm_of(int'(a), sh)) ev_ok = 0;
        exp_ev++;
      end
      a = a + (longint'(1) << sh);
    end
    check(n_lk == exp_lk, req, "R2 lookup count", n_lk, exp_lk);
    check(lk_ok, req, "R1 lookup address sequence", int'(lk_ok), 1);
    check(n_ev == exp_ev, req, "R3 event count", n_ev, exp_ev);
    check(ev_ok, req, "R9 event contents", int'(ev_ok), 1);
    check(n_done == 1, req, "R6 done pulses", n_done, 1);
    exp_done = (exp_lk == 0) ? start_cyc + 1 : last_proc + 2;
    check(done_cyc == exp_done, req, "R6 done cycle", done_cyc, exp_done);
  endtask

  task automatic t_reset();
    check(!busy && !done && !lk_req && !ev_valid, "R6", "reset outputs idle",
          int'({busy, done, lk_req, ev_valid}), 0);
  endtask

  task automatic t_scan(input string req, input int sh, input int cnt,
                        input bit sk, input int st);
    clear_logs(sh, st);
    pulse_start(sh, cnt, sk);
    wait_done();
    judge(req, sh, cnt, sk);
  endtask

  task automatic t_busy_restart();
    clear_logs(6, 1);
    pulse_start(6, 12, 1'b0);
    repeat (9) @(negedge clk);
    check(busy, "R8", "busy mid-scan", int'(busy), 1);
    pulse_start(2, 3, 1'b0);
    wait_done();
    judge("R8", 6, 12, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan("R1", 0, 8, 1'b0, 0);       // fine pages of size 1
    t_scan("R3", 4, 16, 1'b0, 0);      // medium pages, fast consumer
    t_scan("R7", 6, 10, 1'b0, 1);      // throttled consumer
    t_scan("R4", 11, 4, 1'b0, 1);      // window larger than the space
    t_scan("R4", 13, 1, 1'b0, 0);      // page larger than the space
    t_scan("R5", 4, 8, 1'b1, 0);       // skipped scan
    t_scan("R2", 3, 0, 1'b0, 0);       // empty window
    t_busy_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule